// File: doc/BRIEF.md
# Program Counter and Fetch Control with Selectable Branch Delay Slot

This block holds the program counter of a small three-stage in-order core (decode/setup, load/execute, writeback) and decides which address is fetched next. Each cycle it presents `fetch_addr` to the instruction memory. A resolved branch or call from the decode side arrives as a request with a target and a taken flag. The request belongs to the instruction fetched in the previous cycle, so the instruction fetched while the request is presented is the one right after the branch: the delay slot.

A build-time parameter picks how the slot is handled. With `DELAY_SLOT = 1`, the default, the slot instruction always runs. While it runs, the program counter already holds the branch target, so code in the slot must not rely on the program counter. With `DELAY_SLOT = 0`, a taken branch moves the control state machine from `FS_RUN` to `FS_BUBBLE` for exactly one cycle. In that cycle `fetch_nop` tells decode to replace the slot instruction with a no-operation. Any request that would come from that squashed instruction is ignored.

The state machine has two states. `FS_RUN` moves to `FS_BUBBLE` on an accepted taken request when squashing is selected, and otherwise stays in `FS_RUN`. `FS_BUBBLE` always returns to `FS_RUN`. A taken call also produces a one-cycle write strobe for the link register (register 13). The link value is the address of the instruction that follows the delay slot, so a later return does not run the slot again. The program counter width is 8, 16 or 32 bits and may not exceed the register width; other settings stop elaboration.

Top module: `pcu_branch_ctrl`

## Requirements
- R1: A synchronous reset, one clock after it is sampled, gives `fetch_addr` = 0, `fetch_nop` = 0 and `link_we` = 0, and the state machine is in `FS_RUN`.
- R2: When no request is accepted in a cycle, `fetch_addr` in the next cycle is the current value plus `STEP`, wrapping modulo 2^PC_W.
- R3: A request with `req_valid` = 1 and `req_taken` = 1 is accepted when `fetch_nop` = 0. In the next cycle `fetch_addr` equals `req_target`.
- R4: With `DELAY_SLOT` = 1, `fetch_nop` stays 0 at all times. A taken request presented in the cycle right after another accepted request (a branch in the slot) is accepted as well.
- R5: With `DELAY_SLOT` = 0, `fetch_nop` is 1 for exactly the one cycle after an accepted request.
- R6: With `DELAY_SLOT` = 0, a request presented while `fetch_nop` = 1 is ignored: `fetch_addr` advances by `STEP`, and neither a bubble nor a link write follows.
- R7: A request with `req_taken` = 0 never causes a bubble or a link write in either mode, and the program counter advances by `STEP`.
- R8: An accepted request with `req_call` = 1 sets `link_we` = 1 for one cycle in the next cycle. `link_data` then carries the zero-extended value (`fetch_addr` at acceptance + `STEP`) mod 2^PC_W. Accepted requests with `req_call` = 0 leave `link_we` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A resolved branch or call request is present |
| req_taken | input | 1 | The request redirects the program counter |
| req_call | input | 1 | The request is a call and writes the link register |
| req_target | input | PC_W | Resolved target address |
| fetch_addr | output | PC_W | Current program counter, used as the fetch address |
| fetch_nop | output | 1 | Replace the instruction now in decode with a no-operation |
| link_we | output | 1 | Write strobe for the link register |
| link_data | output | REG_W | Return address, zero-extended to register width |

## Verification
A wrong program counter update shows on `fetch_addr` in the very next cycle, because that port is the register itself. A stuck or wrongly entered `FS_BUBBLE` state shows at once on `fetch_nop`. It also shows one cycle later, when a request presented in the squashed cycle either changes `fetch_addr` or fails to change it. A wrong link computation appears on `link_data` in the cycle after the call is accepted. It is visible only while `link_we` is high, so calls are placed at every target value to expose it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Fetch control states: normal sequencing, or the single squash cycle
    typedef enum logic [0:0] {
        FS_RUN    = 1'b0,
        FS_BUBBLE = 1'b1
    } fetch_state_t;

endpackage

// File: rtl/pcu_fsm.sv
module pcu_fsm
    import pcu_pkg::*;
#(
    parameter bit DELAY_SLOT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_taken,
    output logic accept,
    output logic fetch_nop
);

    fetch_state_t state_q;
    fetch_state_t state_d;

    // Next-state and acceptance decision
    always_comb begin
        accept  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            FS_RUN: begin
                accept = req_valid && req_taken;
                if (accept && !DELAY_SLOT) begin
                    state_d = FS_BUBBLE;
                end else begin
                    state_d = FS_RUN;
                end
            end
            FS_BUBBLE: begin
                // the request, if any, came from the squashed slot
                accept  = 1'b0;
                state_d = FS_RUN;
            end
            default: begin
                accept  = 1'b0;
                state_d = FS_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        fetch_nop = (state_q == FS_BUBBLE);
    end

    generate
        if (DELAY_SLOT) begin : g_slot_chk
            // R4: the slot is never squashed
            a_r4_no_bubble: assert property (@(posedge clk) disable iff (rst)
                !fetch_nop);
        end else begin : g_squash_chk
            // R5: a bubble lasts one cycle
            a_r5_single_bubble: assert property (@(posedge clk) disable iff (rst)
                fetch_nop |=> !fetch_nop);
            // R6: nothing is accepted while squashing
            a_r6_ignore_in_bubble: assert property (@(posedge clk) disable iff (rst)
                (fetch_nop && req_valid && req_taken) |=> !fetch_nop);
        end
    endgenerate

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
    parameter int PC_W = 32,
    parameter int STEP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (accept) begin
            pc_q <= target;
        end else begin
            pc_q <= pc_q + STEP_V;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/pcu_link.sv
module pcu_link #(
    parameter int PC_W  = 32,
    parameter int REG_W = 32,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             is_call,
    input  logic [PC_W-1:0]  slot_pc,
    output logic             link_we,
    output logic [REG_W-1:0] link_data
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic             we_q;
    logic [REG_W-1:0] data_q;
    logic [PC_W-1:0]  after_slot;

    // address of the instruction that follows the delay slot
    assign after_slot = slot_pc + STEP_V;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b0;
            data_q <= '0;
        end else begin
            we_q <= accept && is_call;
            if (accept && is_call) begin
                data_q <= REG_W'(after_slot);
            end
        end
    end

    assign link_we   = we_q;
    assign link_data = data_q;

endmodule

// File: rtl/pcu_branch_ctrl.sv
module pcu_branch_ctrl #(
    parameter int PC_W       = 32,
    parameter int REG_W      = 32,
    parameter int STEP       = 2,
    parameter bit DELAY_SLOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_taken,
    input  logic             req_call,
    input  logic [PC_W-1:0]  req_target,
    output logic [PC_W-1:0]  fetch_addr,
    output logic             fetch_nop,
    output logic             link_we,
    output logic [REG_W-1:0] link_data
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    generate
        if (!(PC_W == 8 || PC_W == 16 || PC_W == 32) || PC_W > REG_W) begin : g_bad_cfg
            $error("pcu_branch_ctrl: PC_W must be 8, 16 or 32 and not exceed REG_W");
        end
    endgenerate

    logic accept;

    pcu_fsm #(
        .DELAY_SLOT(DELAY_SLOT)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_taken(req_taken),
        .accept   (accept),
        .fetch_nop(fetch_nop)
    );

    pcu_pc_reg #(
        .PC_W(PC_W),
        .STEP(STEP)
    ) pc_i (
        .clk   (clk),
        .rst   (rst),
        .accept(accept),
        .target(req_target),
        .pc    (fetch_addr)
    );

    pcu_link #(
        .PC_W (PC_W),
        .REG_W(REG_W),
        .STEP (STEP)
    ) link_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .is_call  (req_call),
        .slot_pc  (fetch_addr),
        .link_we  (link_we),
        .link_data(link_data)
    );

    // R1: reset state one clock after reset is sampled
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && !fetch_nop && !link_we));

    // R3: an accepted taken request redirects the next fetch
    a_r3_redirect: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_taken && !fetch_nop) |=> fetch_addr == $past(req_target));

    // R2: sequential advance when nothing is accepted
    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_taken && !fetch_nop) |=> fetch_addr == ($past(fetch_addr) + STEP_V));

    // R7: an untaken request yields no bubble and no link write
    a_r7_untaken_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_taken) |=> (!fetch_nop && !link_we));

    // R8: link value is the address after the delay slot
    a_r8_link_value: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_data == REG_W'(PC_W'($past(fetch_addr) + STEP_V)));

endmodule

// File: tb/pcu_branch_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcu_branch_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_taken = 1'b0;
    logic        req_call  = 1'b0;
    logic [7:0]  req_target = '0;

    logic [7:0]  fa_d, fa_s;
    logic        nop_d, nop_s;
    logic        lwe_d, lwe_s;
    logic [15:0] ld_d, ld_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected state, computed from the requirements
    logic [7:0]  exp_pc_d, exp_pc_s;
    logic        exp_nop_s;
    logic        exp_lwe_d, exp_lwe_s;
    logic [15:0] exp_ld_d, exp_ld_s;
    logic        prev_acc_d;

    always #4 clk = ~clk;

    // delay-slot configuration
    pcu_branch_ctrl #(.PC_W(8), .REG_W(16), .STEP(2), .DELAY_SLOT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_taken(req_taken),
        .req_call(req_call), .req_target(req_target), .fetch_addr(fa_d),
        .fetch_nop(nop_d), .link_we(lwe_d), .link_data(ld_d)
    );

    // squash configuration, same stimulus
    pcu_branch_ctrl #(.PC_W(8), .REG_W(16), .STEP(2), .DELAY_SLOT(1'b0)) dut_sq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_taken(req_taken),
        .req_call(req_call), .req_target(req_target), .fetch_addr(fa_s),
        .fetch_nop(nop_s), .link_we(lwe_s), .link_data(ld_s)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        req_valid = 1'b0;
        req_taken = 1'b0;
        req_call  = 1'b0;
        @(negedge clk);
        chk("R1", "delay fetch_addr", 32'(fa_d), 0);
        chk("R1", "delay fetch_nop", 32'(nop_d), 0);
        chk("R1", "delay link_we", 32'(lwe_d), 0);
        chk("R1", "squash fetch_addr", 32'(fa_s), 0);
        chk("R1", "squash fetch_nop", 32'(nop_s), 0);
        chk("R1", "squash link_we", 32'(lwe_s), 0);
        rst        = 1'b0;
        exp_pc_d   = '0;
        exp_pc_s   = '0;
        exp_nop_s  = 1'b0;
        prev_acc_d = 1'b0;
    endtask

    // one clock: present a request, then compare both instances
    task automatic cyc(input logic v, input logic t, input logic c, input logic [7:0] tgt);
        logic  acc_d, acc_s;
        string tg_d, tg_s, tg_n;
        req_valid  = v;
        req_taken  = t;
        req_call   = c;
        req_target = tgt;
        acc_d = v && t;
        acc_s = v && t && !exp_nop_s;
        tg_d  = acc_d ? (prev_acc_d ? "R4" : "R3") : (v ? "R7" : "R2");
        tg_s  = acc_s ? "R3" : ((v && t) ? "R6" : (v ? "R7" : "R2"));
        tg_n  = (v && !t) ? "R7" : ((v && t && exp_nop_s) ? "R6" : "R5");
        exp_lwe_d = acc_d && c;
        exp_lwe_s = acc_s && c;
        exp_ld_d  = {8'h00, exp_pc_d + 8'd2};
        exp_ld_s  = {8'h00, exp_pc_s + 8'd2};
        exp_pc_d  = acc_d ? tgt : exp_pc_d + 8'd2;
        exp_pc_s  = acc_s ? tgt : exp_pc_s + 8'd2;
        exp_nop_s = acc_s;
        prev_acc_d = acc_d;
        @(negedge clk);
        chk(tg_d, "delay fetch_addr", 32'(fa_d), 32'(exp_pc_d));
        chk(tg_s, "squash fetch_addr", 32'(fa_s), 32'(exp_pc_s));
        chk("R4", "delay fetch_nop", 32'(nop_d), 0);
        chk(tg_n, "squash fetch_nop", 32'(nop_s), 32'(exp_nop_s));
        chk("R8", "delay link_we", 32'(lwe_d), 32'(exp_lwe_d));
        chk("R8", "squash link_we", 32'(lwe_s), 32'(exp_lwe_s));
        if (exp_lwe_d) chk("R8", "delay link_data", 32'(ld_d), 32'(exp_ld_d));
        if (exp_lwe_s) chk("R8", "squash link_data", 32'(ld_s), 32'(exp_ld_s));
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // sweep every target: taken request, a second one in the slot,
        // an idle cycle, then an untaken call
        for (int i = 0; i < 256; i++) begin
            cyc(1'b1, 1'b1, i[0], 8'(i));
            cyc(1'b1, 1'b1, i[1], ~8'(i));
            cyc(1'b0, 1'b0, 1'b0, 8'h00);
            cyc(1'b1, 1'b0, 1'b1, 8'(i));
        end
        // R2 wrap-around of the program counter
        do_reset();
        for (int k = 0; k < 140; k++) cyc(1'b0, 1'b0, 1'b0, 8'h00);
        // R1 reset from a busy state
        cyc(1'b1, 1'b1, 1'b1, 8'hA5);
        do_reset();
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        req_valid = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule